// File: doc/BRIEF.md
# Cascaded 5-to-32 Line Decoder

This block turns a 5-bit code into a one-cold 32-line select bus. Instead of one flat decoder it is built as a two-level tree. A small first-level decoder looks at the two high-order code bits and picks one of four second-level decoders. Each of those four turns the three low-order bits into eight select lines.

The first level has active-low outputs. Each of them drives the active-low enable of one second-level stage, so that stage is the only one that can assert a line. Every second-level stage has three enables: one active-high and two active-low. The tree uses one active-low enable from each stage. The spare active-high enable is tied high and the spare active-low enable is tied low.

A global active-low enable gates the first level, and through it the whole tree. The block is purely combinational and has no clock or reset. It is a control-style block, so its pins are plain levels with no handshake.

Top module: `casc_decoder`

## Requirements
- R1: While `en_n` is 1, all 32 bits of `y_n` are 1, whatever the value of `code`.
- R2: While `en_n` is 0, exactly one bit of `y_n` is 0, and that bit is the one whose index equals the unsigned value of `code`.
- R3: At most one of the four second-level stages is enabled at any moment. None is enabled while `en_n` is 1.
- R4: Stage k, for k from 0 to 3, drives `y_n[8k+7:8k]`. Every output of a stage that is not enabled is 1.
- R5: `code[4:3]` alone picks the stage, and `code[2:0]` alone picks the line within that stage. Two codes that differ only in `code[4:3]` assert lines exactly 8·Δ positions apart, where Δ is the difference between their `code[4:3]` values.
- R6: A second-level stage asserts a line only when its active-high enable is 1 and both of its active-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_n | input | 1 | Global enable, active low |
| code | input | 5 | Code to decode; bits 4:3 pick the stage, bits 2:0 pick the line |
| y_n | output | 32 | One-cold select lines, active low; bit i corresponds to code value i |

## Verification
The bench builds the block with its default split: a 2-bit first level and 3-bit stages, giving 32 outputs. At this size the full input space is only 64 combinations: every code with the enable both low and high. The sweep covers all of them. It compares each output word with a flat reference computed as one shifted bit, so every stage boundary and every line within a stage is reached. The sweep also steps through the codes in order, so it covers each change of the selected stage between neighbouring codes, such as 7 to 8 and 23 to 24.

// File: rtl/casc_dec_pkg.sv
package casc_dec_pkg;
  localparam int unsigned HI_BITS = 2;
  localparam int unsigned LO_BITS = 3;
endpackage

// File: rtl/dec_first_lvl.sv
module dec_first_lvl #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic             en_n,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_N-1:0] out_n
);
  generate
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign out_n[i] = ~(~en_n && (sel == SEL_W'(i)));
    end
  endgenerate

  // R3
  always_comb begin
    first_onehot_chk: assert ($onehot0(~out_n) && (!en_n || (&out_n)))
      else $error("first level enables more than one stage");
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic             en_hi,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_N-1:0] out_n
);
  logic active;
  assign active = en_hi & ~en_a_n & ~en_b_n;

  generate
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
      assign out_n[i] = ~(active && (sel == SEL_W'(i)));
    end
  endgenerate

  // R6
  always_comb begin
    stage_gate_chk: assert ((en_hi && !en_a_n && !en_b_n) ? ($countones(~out_n) == 1) : (&out_n))
      else $error("stage output disagrees with its enables");
  end
endmodule

// File: rtl/casc_decoder.sv
module casc_decoder
  import casc_dec_pkg::*;
#(
  parameter int unsigned HI_W = HI_BITS,
  parameter int unsigned LO_W = LO_BITS,
  localparam int unsigned CODE_W = HI_W + LO_W,
  localparam int unsigned STAGES = 1 << HI_W,
  localparam int unsigned PER_STG = 1 << LO_W,
  localparam int unsigned OUT_W = 1 << CODE_W
) (
  input  logic              en_n,
  input  logic [CODE_W-1:0] code,
  output logic [OUT_W-1:0]  y_n
);
  logic [STAGES-1:0] stage_en_n;

  dec_first_lvl #(.SEL_W(HI_W)) first_i (
    .en_n (en_n),
    .sel  (code[CODE_W-1:LO_W]),
    .out_n(stage_en_n)
  );

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      // R4: stage k owns lines k*PER_STG .. k*PER_STG+PER_STG-1
      dec_stage #(.SEL_W(LO_W)) stage_i (
        .en_hi (1'b1),
        .en_a_n(stage_en_n[k]),
        .en_b_n(1'b0),
        .sel   (code[LO_W-1:0]),
        .out_n (y_n[k*PER_STG +: PER_STG])
      );
    end
  endgenerate

  // R1
  always_comb begin
    off_all_high_chk: assert (!en_n || (&y_n))
      else $error("output asserted while disabled");
  end

  // R2
  always_comb begin
    on_one_cold_chk: assert (en_n || (($countones(~y_n) == 1) && !y_n[code]))
      else $error("wrong line asserted while enabled");
  end
endmodule

// File: tb/casc_decoder_tb.sv
module casc_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_n;
  logic [4:0] code;
  logic [31:0] y_n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  casc_decoder dut_i (.en_n(en_n), .code(code), .y_n(y_n));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s code=%0d en_n=%0b actual=%h expected=%h", req, code, en_n, act, exp);
    end
  endtask

  initial begin
    en_n = 1'b1;
    code = 5'd0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(y_n, 32'hFFFF_FFFF, "R1 idle");
    // R2 R4 R5 R6: enabled sweep against flat reference
    for (int c = 0; c < 32; c++) begin
      @(posedge clk);
      en_n = 1'b0;
      code = 5'(c);
      @(negedge clk);
      check(y_n, ~(32'd1 << c), "R2");
      // R4: untouched stages all high
      for (int k = 0; k < 4; k++)
        if (k != c / 8) check({24'd0, y_n[k*8 +: 8]}, 32'h0000_00FF, "R4");
      // R5: line offset within stage follows code[2:0]
      check({24'd0, y_n[(c/8)*8 +: 8]}, {24'd0, ~(8'd1 << (c % 8))}, "R5");
    end
    // R1 R3: disabled sweep
    for (int c = 31; c >= 0; c--) begin
      @(posedge clk);
      en_n = 1'b1;
      code = 5'(c);
      @(negedge clk);
      check(y_n, 32'hFFFF_FFFF, "R1 R3");
    end
    // R5: toggling only the stage bits moves the line by 8 per step
    @(posedge clk);
    en_n = 1'b0;
    code = 5'b00_101;
    @(negedge clk);
    check(y_n, ~(32'd1 << 5), "R5 base");
    @(posedge clk);
    code = 5'b11_101;
    @(negedge clk);
    check(y_n, ~(32'd1 << 29), "R5 shift");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule